// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes asynchronous serial characters from one data line, which rests high between frames, and delivers each finished character to a receive data register that the host reads. A 16-per-bit tick from an external baud generator drives the receiver. The receiver finds the falling edge of a start bit and checks that the start bit is still low half a bit later. It then samples every later bit at the centre of its cell. Each character is checked for parity, for a valid stop bit and for overrun. The receiver keeps a data-full flag and three error flags, and it raises a data-ready interrupt and an error interrupt.

Each error has its own rule for moving data. On an overrun the new character is dropped and the register keeps the unread one. On a parity or framing error the character is still copied, but the data-full flag stays clear. While any error flag is set, the receiver ignores the line until software clears that flag. The host controls receive enable, interrupt enable, parity enable, parity sense, one or two stop bits and 7- or 8-bit characters. The host clears flags with single-cycle strobes.

Top module: `serial_rx_unit`

## Requirements
- R1: A frame begins only on a high-to-low change of the line seen on consecutive ticks. The line is sampled again 8 ticks later. If it is high then, the event is dropped as a glitch and no flag or data changes.
- R2: Data bits arrive least significant first and fill the register from bit 0 upward. With `len7_i`=1, 7 data bits are taken and bit 7 of `data_o` reads 0.
- R3: With `par_en_i`=1, one parity bit follows the data. The count of ones in the data plus the parity bit must be odd when `par_odd_i`=1 and even when `par_odd_i`=0. A mismatch sets `par_err_o`.
- R4: A 0 in the first stop bit sets `frm_err_o`. With `two_stop_i`=1, the value of the second stop bit is never checked.
- R5: A character with no error is copied to `data_o` and sets `full_o`.
- R6: A character with a parity or framing error is still copied to `data_o`, but `full_o` stays 0.
- R7: If `full_o` is still 1 when a character completes, `ovr_err_o` is set, `data_o` keeps the earlier character and `full_o` stays 1.
- R8: While any of `ovr_err_o`, `frm_err_o` or `par_err_o` is 1, incoming frames are ignored. After the flags are cleared, reception resumes.
- R9: `clr_full_i` clears `full_o` only if a `rd_data_i` strobe came while `full_o` was 1. Each error flag clears on its own strobe (`clr_ovr_i`, `clr_frm_i`, `clr_par_i`).
- R10: `irq_rx_o` is `full_o` AND `irq_en_i`. `irq_err_o` is (any error flag) AND `irq_en_i`.
- R11: With `rx_en_i`=0, the line is ignored and nothing changes.
- R12: After reset, `data_o` is 0 and every flag and interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle pulse, 16 per bit time |
| rxd_i | input | 1 | Serial data line, idle high |
| rx_en_i | input | 1 | Receive enable |
| irq_en_i | input | 1 | Interrupt enable for both interrupts |
| par_en_i | input | 1 | A parity bit follows the data |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| two_stop_i | input | 1 | 1 = two stop bits |
| len7_i | input | 1 | 1 = 7 data bits, 0 = 8 |
| rd_data_i | input | 1 | Host read of the data register |
| clr_full_i | input | 1 | Write 0 to the data-full flag |
| clr_ovr_i | input | 1 | Clear the overrun flag |
| clr_frm_i | input | 1 | Clear the framing flag |
| clr_par_i | input | 1 | Clear the parity flag |
| data_o | output | 8 | Receive data register |
| full_o | output | 1 | Data-full flag |
| ovr_err_o | output | 1 | Overrun error flag |
| frm_err_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| irq_rx_o | output | 1 | Data-ready interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The bench sends a second character while the first is still unread. A design that copied on overrun would replace the unread byte, and one that cleared the full flag would lose it. It checks that a parity or framing error still updates the data register but leaves the full flag clear, and that a following good frame is fully ignored until the flag is cleared. A receiver that kept running would update the data there. It sends a short low pulse, a 7-bit character with bit 7 forced, and a low second stop bit. These catch a receiver that starts on any low level, one that leaks bit 7, and one that checks the second stop bit. It also tries to clear the full flag without a prior read; a single-strobe clear would wrongly drop the flag.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          par_bad;
        logic          stop_bad;
    } rx_result_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rxd_i,
    input  logic       run_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       two_stop_i,
    input  logic       len7_i,
    output logic       done_o,
    output rx_result_t res_o
);
    localparam int unsigned CW  = $clog2(OVS);
    localparam int unsigned BW  = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] idx;
        logic [DW-1:0] sr;
        logic          pbit;
        logic          prev;
    } frame_t;

    frame_t d, q;
    logic [BW-1:0] last_idx;
    logic          done;

    assign last_idx = len7_i ? BW'(DW-2) : BW'(DW-1);

    always_comb begin
        d    = q;
        done = 1'b0;
        if (tick_i) d.prev = rxd_i;
        unique case (q.st)
            ST_IDLE: begin
                if (run_i && tick_i && q.prev && !rxd_i) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                    d.sr  = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rxd_i ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt        = '0;
                        d.sr[q.idx]  = rxd_i;
                        if (q.idx == last_idx) d.st = par_en_i ? ST_PAR : ST_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        d.pbit = rxd_i;
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        done  = 1'b1;
                        d.cnt = '0;
                        d.st  = two_stop_i ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (tick_i) begin
                    if (q.cnt == LAST) d.st = ST_IDLE;
                    else               d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!run_i) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o         = done && run_i;
    assign res_o.data     = q.sr;
    assign res_o.stop_bad = !rxd_i;
    assign res_o.par_bad  = par_en_i && ((^q.sr ^ q.pbit) != par_odd_i);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  rx_result_t    res_i,
    input  logic          rd_i,
    input  logic          clr_full_i,
    input  logic          clr_ovr_i,
    input  logic          clr_frm_i,
    input  logic          clr_par_i,
    output logic [DW-1:0] rdr_o,
    output logic          full_o,
    output logic          ovr_o,
    output logic          frm_o,
    output logic          par_o
);
    typedef struct packed {
        logic [DW-1:0] rdr;
        logic          full;
        logic          rd_seen;
        logic          ovr;
        logic          frm;
        logic          par;
    } status_t;

    status_t d, q;

    always_comb begin
        d = q;
        if (rd_i && q.full) d.rd_seen = 1'b1;
        if (clr_full_i && q.rd_seen) begin
            d.full    = 1'b0;
            d.rd_seen = 1'b0;
        end
        if (clr_ovr_i) d.ovr = 1'b0;
        if (clr_frm_i) d.frm = 1'b0;
        if (clr_par_i) d.par = 1'b0;
        if (done_i) begin
            if (q.full) d.ovr = 1'b1;
            else        d.rdr = res_i.data;
            if (res_i.stop_bad) d.frm = 1'b1;
            if (res_i.par_bad)  d.par = 1'b1;
            if (!q.full && !res_i.stop_bad && !res_i.par_bad) begin
                d.full    = 1'b1;
                d.rd_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdr_o  = q.rdr;
    assign full_o = q.full;
    assign ovr_o  = q.ovr;
    assign frm_o  = q.frm;
    assign par_o  = q.par;
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick_i,
    input  logic          rxd_i,
    input  logic          rx_en_i,
    input  logic          irq_en_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          two_stop_i,
    input  logic          len7_i,
    input  logic          rd_data_i,
    input  logic          clr_full_i,
    input  logic          clr_ovr_i,
    input  logic          clr_frm_i,
    input  logic          clr_par_i,
    output logic [DW-1:0] data_o,
    output logic          full_o,
    output logic          ovr_err_o,
    output logic          frm_err_o,
    output logic          par_err_o,
    output logic          irq_rx_o,
    output logic          irq_err_o
);
    logic       rxd_s;
    logic       done;
    logic       run;
    logic       any_err;
    rx_result_t res;

    serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rxd_i),
        .sync_o  (rxd_s)
    );

    assign any_err = ovr_err_o || frm_err_o || par_err_o;
    assign run     = rx_en_i && !any_err;

    serial_rx_frame #(.OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (baud_tick_i),
        .rxd_i      (rxd_s),
        .run_i      (run),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .two_stop_i (two_stop_i),
        .len7_i     (len7_i),
        .done_o     (done),
        .res_o      (res)
    );

    serial_rx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .res_i      (res),
        .rd_i       (rd_data_i),
        .clr_full_i (clr_full_i),
        .clr_ovr_i  (clr_ovr_i),
        .clr_frm_i  (clr_frm_i),
        .clr_par_i  (clr_par_i),
        .rdr_o      (data_o),
        .full_o     (full_o),
        .ovr_o      (ovr_err_o),
        .frm_o      (frm_err_o),
        .par_o      (par_err_o)
    );

    assign irq_rx_o  = full_o && irq_en_i;
    assign irq_err_o = any_err && irq_en_i;
endmodule

// File: rtl/serial_rx_unit_chk.sv
module serial_rx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       len7_i,
    input logic       clr_full_i,
    input logic [7:0] data_o,
    input logic       full_o,
    input logic       ovr_err_o,
    input logic       frm_err_o,
    input logic       par_err_o,
    input logic       irq_err_o
);
    // R5 / R6: the data-full flag never rises together with a new error
    assert_full_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> !($rose(frm_err_o) || $rose(par_err_o) || $rose(ovr_err_o)));

    // R7: an overrun leaves the data register untouched
    assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err_o) |-> (data_o == $past(data_o)));

    // R8: no new character is accepted while an error flag is pending
    assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr_err_o || frm_err_o || par_err_o) |-> !$rose(full_o));

    // R9: the data-full flag only falls after a clear strobe
    assert_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_o) |-> $past(clr_full_i));

    // R10: the error interrupt needs a pending error flag
    assert_err_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_o |-> (ovr_err_o || frm_err_o || par_err_o));

    // R2: 7-bit characters keep the top data bit at 0
    assert_len7_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(full_o) && len7_i) |-> !data_o[7]);
endmodule

bind serial_rx_unit serial_rx_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .len7_i     (len7_i),
    .clr_full_i (clr_full_i),
    .data_o     (data_o),
    .full_o     (full_o),
    .ovr_err_o  (ovr_err_o),
    .frm_err_o  (frm_err_o),
    .par_err_o  (par_err_o),
    .irq_err_o  (irq_err_o)
);

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
    localparam int DIV = 4;
    localparam int BITCLK = 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick_i = 1'b0;
    logic rxd_i = 1'b1;
    logic rx_en_i = 1'b0, irq_en_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
    logic two_stop_i = 1'b0, len7_i = 1'b0, rd_data_i = 1'b0, clr_full_i = 1'b0;
    logic clr_ovr_i = 1'b0, clr_frm_i = 1'b0, clr_par_i = 1'b0;
    logic [7:0] data_o;
    logic full_o, ovr_err_o, frm_err_o, par_err_o, irq_rx_o, irq_err_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            baud_tick_i = (c == DIV-1);
            c = (c == DIV-1) ? 0 : c + 1;
        end
    end

    serial_rx_unit u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick_i(baud_tick_i), .rxd_i(rxd_i),
        .rx_en_i(rx_en_i), .irq_en_i(irq_en_i), .par_en_i(par_en_i),
        .par_odd_i(par_odd_i), .two_stop_i(two_stop_i), .len7_i(len7_i),
        .rd_data_i(rd_data_i), .clr_full_i(clr_full_i), .clr_ovr_i(clr_ovr_i),
        .clr_frm_i(clr_frm_i), .clr_par_i(clr_par_i), .data_o(data_o),
        .full_o(full_o), .ovr_err_o(ovr_err_o), .frm_err_o(frm_err_o),
        .par_err_o(par_err_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rxd_i = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    // bad_par flips the parity bit; stop1/stop2 give the stop bit values
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic stop1, input logic stop2);
        int nb;
        logic p;
        nb = len7_i ? 7 : 8;
        p = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            send_bit(d[i]);
            p = p ^ d[i];
        end
        if (par_en_i) send_bit((par_odd_i ? ~p : p) ^ bad_par);
        send_bit(stop1);
        if (two_stop_i) send_bit(stop2);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
        @(negedge clk);
    endtask

    task automatic release_full();
        pulse(rd_data_i);
        pulse(clr_full_i);
    endtask

    task automatic t_reset();
        chk("R12 data", data_o, 8'h00);
        chk("R12 flags", {full_o, ovr_err_o, frm_err_o, par_err_o, irq_rx_o, irq_err_o}, 6'b0);
    endtask

    task automatic t_basic();
        send_frame(8'hD2, 1'b0, 1'b1, 1'b1);
        chk("R2 lsb-first data", data_o, 8'hD2);
        chk("R5 full set", full_o, 1'b1);
        chk("R5 no errors", {ovr_err_o, frm_err_o, par_err_o}, 3'b0);
        chk("R10 irq_rx off when disabled", irq_rx_o, 1'b0);
        irq_en_i = 1'b1;
        @(negedge clk);
        chk("R10 irq_rx", irq_rx_o, 1'b1);
        irq_en_i = 1'b0;
        pulse(clr_full_i);
        chk("R9 clear without read ignored", full_o, 1'b1);
        release_full();
        chk("R9 clear after read", full_o, 1'b0);
    endtask

    task automatic t_parity();
        par_en_i = 1'b1; par_odd_i = 1'b0;
        send_frame(8'h5B, 1'b0, 1'b1, 1'b1);
        chk("R3 even parity ok", {full_o, par_err_o}, 2'b10);
        chk("R3 even data", data_o, 8'h5B);
        release_full();
        par_odd_i = 1'b1;
        send_frame(8'h3A, 1'b0, 1'b1, 1'b1);
        chk("R3 odd parity ok", {full_o, par_err_o}, 2'b10);
        release_full();
        irq_en_i = 1'b1;
        send_frame(8'hC4, 1'b1, 1'b1, 1'b1);
        chk("R3 parity error flag", par_err_o, 1'b1);
        chk("R6 data copied on parity error", data_o, 8'hC4);
        chk("R6 full stays clear", full_o, 1'b0);
        chk("R10 irq_err", irq_err_o, 1'b1);
        irq_en_i = 1'b0;
        // R8: the line is ignored while the parity flag is up
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        chk("R8 blocked data", data_o, 8'hC4);
        chk("R8 blocked full", full_o, 1'b0);
        pulse(clr_par_i);
        chk("R9 parity flag cleared", par_err_o, 1'b0);
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        chk("R8 resumes after clear", {data_o, full_o}, {8'h77, 1'b1});
        release_full();
        par_en_i = 1'b0; par_odd_i = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h69, 1'b0, 1'b0, 1'b1);
        chk("R4 framing flag", frm_err_o, 1'b1);
        chk("R6 data copied on framing error", data_o, 8'h69);
        chk("R6 full clear on framing error", full_o, 1'b0);
        pulse(clr_frm_i);
        chk("R9 framing flag cleared", frm_err_o, 1'b0);
        two_stop_i = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1, 1'b0);
        chk("R4 second stop unchecked", {frm_err_o, full_o}, 2'b01);
        chk("R4 two-stop data", data_o, 8'h81);
        release_full();
        two_stop_i = 1'b0;
    endtask

    task automatic t_overrun();
        send_frame(8'h12, 1'b0, 1'b1, 1'b1);
        send_frame(8'h34, 1'b0, 1'b1, 1'b1);
        chk("R7 overrun flag", ovr_err_o, 1'b1);
        chk("R7 old data kept", data_o, 8'h12);
        chk("R7 full stays set", full_o, 1'b1);
        pulse(clr_ovr_i);
        release_full();
        chk("R9 overrun and full cleared", {ovr_err_o, full_o}, 2'b00);
    endtask

    task automatic t_len7();
        len7_i = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b1, 1'b1);
        chk("R2 7-bit data top bit zero", data_o, 8'h7F);
        release_full();
        par_en_i = 1'b1;
        send_frame(8'h25, 1'b0, 1'b1, 1'b1);
        chk("R2 7-bit with parity", {data_o, full_o, par_err_o}, {8'h25, 1'b1, 1'b0});
        release_full();
        par_en_i = 1'b0;
        len7_i = 1'b0;
    endtask

    task automatic t_glitch();
        rxd_i = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rxd_i = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk("R1 glitch ignored", {data_o, full_o, ovr_err_o, frm_err_o, par_err_o},
            {8'h25, 4'b0});
        send_frame(8'hB4, 1'b0, 1'b1, 1'b1);
        chk("R1 frame after glitch", {data_o, full_o}, {8'hB4, 1'b1});
        release_full();
    endtask

    task automatic t_disabled();
        rx_en_i = 1'b0;
        send_frame(8'h0F, 1'b0, 1'b1, 1'b1);
        chk("R11 disabled ignores line", {data_o, full_o}, {8'hB4, 1'b0});
        rx_en_i = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        rx_en_i = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        t_basic();
        t_parity();
        t_framing();
        t_overrun();
        t_len7();
        t_glitch();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule